// File: doc/BRIEF.md
# Two-Operand NaN Propagation Selector

This unit decides which NaN becomes the result of a two-input floating-point operation when at least one of the two operands is a NaN. Each operand arrives with its raw encoding and a two-bit class tag that the caller has already worked out: ordinary value, quiet NaN or signaling NaN. A three-bit policy input chooses one of five priority schemes. One of them breaks ties on the magnitude of the significand. The chosen NaN leaves the unit quieted. Whenever either input is a signaling NaN, the unit raises an invalid-operation flag.

A default-NaN enable overrides the selection and returns the canonical NaN. The invalid flag still follows the operand classes in this mode. Inputs are captured on a cycle where `in_valid` is high. All outputs are registered and appear on the next cycle. The float format is set by the parameters `EXP_W` and `FRAC_W`. The defaults give single precision. The fraction MSB is the quiet bit: 1 means quiet.

Top module: `nan_pick`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `res_val`, `res_from_b` and `inv_flag` change only after an accepted input, and otherwise hold their values.
- R2: Policy 0 selects as follows: B (`res_from_b`=1) if A is not a signaling NaN and B is. Otherwise A if A is any NaN. Otherwise B.
- R3: Policy 1 mirrors policy 0. It selects A if B is not a signaling NaN and A is. Otherwise B if B is any NaN. Otherwise A.
- R4: Policy 2 selects A if A is any NaN, otherwise B. Policy 3 selects B if B is any NaN, otherwise A.
- R5: Policy 4, mixed classes: a quiet NaN beats a signaling NaN, and any NaN beats an ordinary value.
- R6: Policy 4, same NaN class on both sides: the operand with the larger fraction field (unsigned) wins. On equal fractions, A wins only if A is positive and B is negative; otherwise B wins.
- R7: `inv_flag` is 1 exactly when either operand class is signaling NaN (class code 2). Class codes: 0 = ordinary, 1 = quiet NaN, 2 = signaling NaN.
- R8: If the selected operand is a signaling NaN, the result is its encoding with the fraction MSB set. Otherwise the result is the selected encoding unchanged.
- R9: With `dflt_en` high, `res_val` is the canonical NaN (sign 0, exponent all ones, fraction MSB only). `res_from_b` still reports the policy choice and `inv_flag` still follows R7.
- R10: Policy codes 5 to 7 behave exactly like policy 0.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| a_kind | input | 2 | Class of operand A (0 ordinary, 1 quiet, 2 signaling) |
| b_kind | input | 2 | Class of operand B |
| a_val | input | 1+EXP_W+FRAC_W | Encoding of operand A |
| b_val | input | 1+EXP_W+FRAC_W | Encoding of operand B |
| policy | input | 3 | Selection policy code |
| dflt_en | input | 1 | Return the canonical NaN instead of the selected one |
| res_val | output | 1+EXP_W+FRAC_W | Resulting NaN encoding |
| res_from_b | output | 1 | Policy chose operand B |
| inv_flag | output | 1 | Invalid-operation flag |
| out_valid | output | 1 | Outputs belong to an accepted input |

## Verification
Every result is due exactly one clock edge after the cycle in which `in_valid` was high, because one register stage lies between the inputs and the outputs. The bench drives inputs on a falling edge and samples on the next falling edge, which is half a cycle after the capturing rising edge. It then drops `in_valid` and samples one more falling edge later. There it expects `out_valid` low and every other output unchanged.

// File: rtl/nan_pick.sv
module nan_pick #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [1:0]                a_kind,
  input  logic [1:0]                b_kind,
  input  logic [EXP_W+FRAC_W:0]     a_val,
  input  logic [EXP_W+FRAC_W:0]     b_val,
  input  logic [2:0]                policy,
  input  logic                      dflt_en,
  output logic [EXP_W+FRAC_W:0]     res_val,
  output logic                      res_from_b,
  output logic                      inv_flag,
  output logic                      out_valid
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [W-1:0] QBIT  = W'(1) << (FRAC_W - 1);
  localparam logic [W-1:0] CANON = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic a_sn, b_sn, a_qn, b_qn, a_nan, b_nan, a_big, take_b;
  logic [W-1:0] pick;

  assign a_sn  = a_kind == 2'd2;
  assign b_sn  = b_kind == 2'd2;
  assign a_qn  = a_kind == 2'd1;
  assign b_qn  = b_kind == 2'd1;
  assign a_nan = a_sn | a_qn;
  assign b_nan = b_sn | b_qn;

  assign a_big = (a_val[FRAC_W-1:0] > b_val[FRAC_W-1:0]) ||
                 ((a_val[FRAC_W-1:0] == b_val[FRAC_W-1:0]) && !a_val[W-1] && b_val[W-1]);

  always_comb begin
    case (policy)
      3'd1:    take_b = !(a_sn && !b_sn) && (b_nan || !a_nan);
      3'd2:    take_b = !a_nan;
      3'd3:    take_b = b_nan;
      3'd4: begin
        if (a_sn)      take_b = b_qn || (b_sn && !a_big);
        else if (a_qn) take_b = b_qn && !a_big;
        else           take_b = 1'b1;
      end
      default: take_b = (b_sn && !a_sn) || (!a_nan);
    endcase
  end

  assign pick = take_b ? (b_sn ? (b_val | QBIT) : b_val)
                       : (a_sn ? (a_val | QBIT) : a_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_val    <= '0;
      res_from_b <= 1'b0;
      inv_flag   <= 1'b0;
      out_valid  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_val    <= dflt_en ? CANON : pick;
        res_from_b <= take_b;
        inv_flag   <= a_sn | b_sn;
      end
    end
  end
endmodule

module nan_pick_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [1:0]            a_kind,
  input logic [1:0]            b_kind,
  input logic [EXP_W+FRAC_W:0] a_val,
  input logic [EXP_W+FRAC_W:0] b_val,
  input logic [2:0]            policy,
  input logic                  dflt_en,
  input logic [EXP_W+FRAC_W:0] res_val,
  input logic                  res_from_b,
  input logic                  inv_flag,
  input logic                  out_valid
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0; else armed <= 1'b1;

  p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_valid == $past(in_valid)));

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(in_valid)) |-> ($stable(res_val) && $stable(inv_flag) && $stable(res_from_b)));

  p_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid)) |-> (inv_flag == ($past(a_kind) == 2'd2 || $past(b_kind) == 2'd2)));

  p_rule2_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid) && $past(policy) == 3'd2 && $past(a_kind) != 2'd0) |-> !res_from_b);

  p_quiet_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid) && ($past(a_kind) != 2'd0 || $past(b_kind) != 2'd0)) |->
      res_val[FRAC_W-1]);

  p_default_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid) && $past(dflt_en)) |->
      (res_val == {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}}));
endmodule

bind nan_pick nan_pick_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/nan_pick_bench.sv
module nan_pick_bench;
  localparam int EXP_W = 8;
  localparam int FRAC_W = 23;
  localparam int W = 1 + EXP_W + FRAC_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] a_kind = '0, b_kind = '0;
  logic [W-1:0] a_val = '0, b_val = '0;
  logic [2:0] policy = '0;
  logic dflt_en = 1'b0;
  logic [W-1:0] res_val;
  logic res_from_b, inv_flag, out_valid;

  int n_run = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nan_pick u_nan_pick (.clk, .rst_n, .in_valid, .a_kind, .b_kind, .a_val, .b_val,
                       .policy, .dflt_en, .res_val, .res_from_b, .inv_flag, .out_valid);

  task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [W-1:0] make_op(int k);
    logic [W-1:0] v;
    v = W'($urandom);
    if (k == 0) begin
      if (v[W-2 -: EXP_W] == '1) v[W-2] = 1'b0;
    end else begin
      v[W-2 -: EXP_W] = '1;
      v[FRAC_W-1] = (k == 1);
      if (k == 2 && v[FRAC_W-2:0] == '0) v[0] = 1'b1;
    end
    return v;
  endfunction

  function automatic bit model_b(int pol, int ka, int kb, logic [W-1:0] av, logic [W-1:0] bv);
    bit asn = (ka == 2), bsn = (kb == 2), aq = (ka == 1), bq = (kb == 1);
    bit an = asn || aq, bn = bsn || bq, abig;
    abig = (av[FRAC_W-1:0] > bv[FRAC_W-1:0]) ||
           (av[FRAC_W-1:0] == bv[FRAC_W-1:0] && av[W-1] == 1'b0 && bv[W-1] == 1'b1);
    case (pol)
      1: begin if (bsn) return 1; if (asn) return 0; if (bq) return 1; return 0; end
      2: return !an;
      3: return bn;
      4: begin
        if (an && !bn) return 0;
        if (bn && !an) return 1;
        if (asn && bq) return 1;
        if (aq && bsn) return 0;
        return !abig;
      end
      default: begin if (asn) return 0; if (bsn) return 1; if (aq) return 0; return 1; end
    endcase
  endfunction

  function automatic string rtag(int pol);
    case (pol)
      0: return "R2"; 1: return "R3"; 2, 3: return "R4"; 4: return "R5/R6";
      default: return "R10";
    endcase
  endfunction

  task automatic run_op(int pol, int ka, int kb, logic [W-1:0] av, logic [W-1:0] bv, bit dm);
    bit eb;
    logic [W-1:0] er, sel;
    int sk;
    eb = model_b(pol, ka, kb, av, bv);
    sel = eb ? bv : av;
    sk = eb ? kb : ka;
    er = (sk == 2) ? (sel | (W'(1) << (FRAC_W - 1))) : sel;
    if (dm) er = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    @(negedge clk);
    a_kind = 2'(ka); b_kind = 2'(kb); a_val = av; b_val = bv;
    policy = 3'(pol); dflt_en = dm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 out_valid", W'(out_valid), W'(1));
    check({rtag(pol), " winner"}, W'(res_from_b), W'(eb));
    check(dm ? "R9 result" : "R8 result", res_val, er);
    check("R7 invalid", W'(inv_flag), W'(ka == 2 || kb == 2));
    a_val = ~a_val; b_val = ~b_val; a_kind = 2'd2; b_kind = 2'd2;
    @(negedge clk);
    check("R1 idle valid", W'(out_valid), W'(0));
    check("R1 hold", res_val, er);
    check("R1 hold flag", W'(inv_flag), W'(ka == 2 || kb == 2));
  endtask

  initial begin
    void'($urandom(32'd1234));
    #1;
    check("R11 res", res_val, '0);
    check("R11 valid", W'({out_valid, inv_flag, res_from_b}), '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int p = 0; p < 8; p++) begin
      for (int ka = 0; ka < 3; ka++) begin
        for (int kb = 0; kb < 3; kb++) begin
          if (ka != 0 || kb != 0) run_op(p, ka, kb, make_op(ka), make_op(kb), 1'b0);
        end
      end
    end
    // R6 ties on equal fractions
    run_op(4, 2, 2, {1'b0, 8'hFF, 23'h00_1234}, {1'b1, 8'hFF, 23'h00_1234}, 1'b0);
    run_op(4, 1, 1, {1'b1, 8'hFF, 23'h40_0077}, {1'b0, 8'hFF, 23'h40_0077}, 1'b0);
    run_op(4, 1, 1, {1'b0, 8'hFF, 23'h40_0077}, {1'b0, 8'hFF, 23'h40_0077}, 1'b0);
    run_op(4, 2, 2, {1'b1, 8'hFF, 23'h00_0002}, {1'b0, 8'hFF, 23'h00_0001}, 1'b0);
    run_op(4, 1, 1, {1'b0, 8'hFF, 23'h40_0001}, {1'b1, 8'hFF, 23'h7F_FFFF}, 1'b0);
    // R9 default mode
    run_op(0, 2, 1, make_op(2), make_op(1), 1'b1);
    run_op(3, 0, 1, make_op(0), make_op(1), 1'b1);
    for (int i = 0; i < 600; i++) begin
      int ka, kb;
      ka = int'($urandom % 3);
      kb = int'($urandom % 3);
      if (ka == 0 && kb == 0) kb = 1 + int'($urandom % 2);
      run_op(int'($urandom % 8), ka, kb, make_op(ka), make_op(kb), ($urandom % 6) == 0);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_run++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule